// File: doc/BRIEF.md
# Line-Fill Read Buffer

This block serves 32-bit word reads that a DSP memory port issues into an external window, from one cached line of four 32-bit words (128 bits). Behind it sits a 16-bit SDRAM back end, modelled as a plain burst engine. On a hit the block answers in the same cycle. On a miss it stalls the processor and requests an eight-beat burst of 16-bit reads. It packs the beats into the line and then releases the requested word.

The processor side uses a request/valid/stall handshake. A read completes in the cycle where `rd_valid` is high. While `rd_stall` is high, the processor holds `rd_req` and `rd_addr` steady. The port only reads; nothing is ever written towards the memory. An invalidate input lets the system drop the cached line after an external write, so a stale copy is never served.

Top module: `lfb_read_buffer`

## Requirements
- R1: After reset the line is invalid and `rd_valid`, `rd_stall` and `burst_req` are all low. The first read in the window is therefore a miss.
- R2: Only processor addresses with bit 15 set (8000H to FFFFH) are served. A request with bit 15 clear never raises `rd_stall` or `rd_valid` and never starts a burst, even when its bits [14:2] equal the cached tag.
- R3: A miss produces exactly one single-cycle `burst_req` pulse in the cycle after the miss is seen. `burst_addr` then equals `{rd_addr[14:2], 3'b000}`, which is the line-aligned 16-bit beat address.
- R4: Beat k of a burst (k = 0..7, in ascending order) fills 16-bit half k mod 2 of word k/2. Half 0 is bits [15:0]. The returned word at offset w is therefore `{beat(2w+1), beat(2w)}`.
- R5: During a refill `rd_stall` stays high and `rd_valid` stays low. The requested word appears with `rd_valid` in the cycle right after the eighth beat is accepted.
- R6: A hit (line valid and `rd_addr[14:2]` equal to the stored tag) gives `rd_valid` high in the same cycle, with `rd_data` set to the word chosen by `rd_addr[1:0]`. A hit does not stall and does not start a burst.
- R7: A read whose `rd_addr[14:2]` differs from the stored tag misses and replaces the whole line.
- R8: A one-cycle pulse on `invalidate` while idle clears the line, so the next read of the same line misses.
- R9: An `invalidate` pulse during a refill lets the refill finish, but leaves the line invalid. The held request then misses again and fetches the line anew.
- R10: A `beat_valid` that arrives while no refill is in progress is ignored, and the cached line keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Processor read request, held while stalled |
| rd_addr | input | 16 | Processor word address; bit 15 selects the external window |
| rd_data | output | 32 | Read word, meaningful while `rd_valid` is high |
| rd_valid | output | 1 | Read completes in this cycle |
| rd_stall | output | 1 | Request in the window cannot complete yet |
| invalidate | input | 1 | Drop the cached line |
| burst_req | output | 1 | One-cycle request for an eight-beat read burst |
| burst_addr | output | 16 | 16-bit beat address of the first beat of the burst |
| beat_valid | input | 1 | A burst beat is present on `beat_data` |
| beat_data | input | 16 | Burst beat data |

## Verification
Several properties are checked on every cycle by assertions. A burst request is a single-cycle pulse, and it only follows an in-window request. No burst follows a completed hit. The line is invalid after an invalidate, and it is valid after a clean refill. The correctness of the beat packing, the exact cycle in which the word returns after the eighth beat, and the re-fetch after an invalidate during a refill can only be shown by the bench scenarios. These scenarios compare the returned data and the burst counts against a memory model. The ignored stray beats and the window boundary are shown the same way, by reading the line back afterwards.

// File: rtl/lfb_pkg.sv
// Package: shared types of the line-fill read buffer.
// Assumes: nothing beyond SystemVerilog 2017.
package lfb_pkg;

    // Refill sequencer state: waiting for a miss, or collecting burst beats.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } lfb_state_t;

endpackage

// File: rtl/lfb_ctrl.sv
// Module: refill sequencer. Starts a burst on a miss, counts incoming beats,
// flags the last one and remembers an invalidate seen mid-refill.
// Assumes: the back end delivers exactly BEATS beats per burst_req pulse,
// in ascending order, one per beat_valid cycle.
module lfb_ctrl
    import lfb_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int CNT_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_miss,
    input  logic             beat_valid,
    input  logic             invalidate,
    output logic             busy,
    output logic             beat_we,
    output logic [CNT_W-1:0] beat_idx,
    output logic             fill_done,
    output logic             stale,
    output logic             burst_req
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    lfb_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stale_q;
    logic             breq_q;

    // Beat acceptance and last-beat detection.
    assign beat_we   = (state_q == ST_FILL) && beat_valid;
    assign fill_done = beat_we && (cnt_q == LAST);
    assign busy      = (state_q == ST_FILL);
    assign beat_idx  = cnt_q;
    assign stale     = stale_q;
    assign burst_req = breq_q;

    // State, beat counter, burst pulse and mid-refill invalidate memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            stale_q <= 1'b0;
            breq_q  <= 1'b0;
        end else begin
            breq_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (lookup_miss) begin
                        state_q <= ST_FILL;
                        cnt_q   <= '0;
                        stale_q <= 1'b0;
                        breq_q  <= 1'b1;
                    end
                end
                default: begin
                    stale_q <= stale_q | invalidate;
                    if (beat_we) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    AST_BURST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |=> !burst_req); // R3

endmodule

// File: rtl/lfb_tag.sv
// Module: line tag and valid flag. Compares a lookup tag against the stored
// line, captures the new tag when a refill starts, and validates the line
// after a clean refill.
// Assumes: start and fill_done are never high in the same cycle.
module lfb_tag #(
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic             fill_done,
    input  logic             stale,
    input  logic             invalidate,
    output logic [TAG_W-1:0] tag,
    output logic             hit
);

    logic [TAG_W-1:0] tag_q;
    logic             valid_q;

    // Hit when the stored line is valid and carries the looked-up tag.
    assign hit = valid_q && (tag_q == lookup_tag);
    assign tag = tag_q;

    // Tag capture on a miss, valid update on refill end or invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else if (start) begin
            tag_q   <= lookup_tag;
            valid_q <= 1'b0;
        end else if (fill_done) begin
            valid_q <= !(stale || invalidate);
        end else if (invalidate) begin
            valid_q <= 1'b0;
        end
    end

    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !valid_q); // R8
    AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !stale && !invalidate) |=> valid_q); // R5

endmodule

// File: rtl/lfb_line.sv
// Module: line data store. Writes one 16-bit beat per accepted beat at the
// position given by the beat index, and reads a full word by word offset.
// Assumes: WORD_W is a whole multiple of BEAT_W.
module lfb_line #(
    parameter int WORD_W     = 32,
    parameter int BEAT_W     = 16,
    parameter int LINE_WORDS = 4,
    localparam int HALVES    = WORD_W / BEAT_W,
    localparam int BEATS     = LINE_WORDS * HALVES,
    localparam int CNT_W     = $clog2(BEATS),
    localparam int OFS_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_we,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [BEAT_W-1:0] beat_data,
    input  logic [OFS_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_word
);

    logic [BEATS*BEAT_W-1:0] line_q;

    // Beat storage: ascending beats fill ascending 16-bit slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (beat_we) begin
            line_q[int'(beat_idx)*BEAT_W +: BEAT_W] <= beat_data;
        end
    end

    // Word read: lower beat of a pair is the lower half of the word.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign rd_word[h*BEAT_W +: BEAT_W] =
            line_q[(int'(rd_sel)*HALVES + h)*BEAT_W +: BEAT_W];
    end

endmodule

// File: rtl/lfb_read_buffer.sv
// Module: single-line read buffer between a DSP read port and a 16-bit
// burst back end. Hits are answered combinationally; misses stall the
// request, fetch the whole line as one burst, then complete.
// Assumes: the processor holds rd_req/rd_addr while rd_stall is high; the
// address MSB selects the external window; the back end answers every
// burst_req with BEATS ascending beats.
module lfb_read_buffer #(
    parameter int PADDR_W    = 16,
    parameter int WORD_W     = 32,
    parameter int BEAT_W     = 16,
    parameter int LINE_WORDS = 4,
    localparam int ADDR_W    = PADDR_W - 1,
    localparam int OFS_W     = $clog2(LINE_WORDS),
    localparam int HALVES    = WORD_W / BEAT_W,
    localparam int BEATS     = LINE_WORDS * HALVES,
    localparam int CNT_W     = $clog2(BEATS),
    localparam int TAG_W     = ADDR_W - OFS_W,
    localparam int HALF_SH   = $clog2(HALVES),
    localparam int BADDR_W   = ADDR_W + HALF_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic [PADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               rd_stall,
    input  logic               invalidate,
    output logic               burst_req,
    output logic [BADDR_W-1:0] burst_addr,
    input  logic               beat_valid,
    input  logic [BEAT_W-1:0]  beat_data
);

    logic             in_win;
    logic [TAG_W-1:0] lookup_tag;
    logic [TAG_W-1:0] line_tag;
    logic             hit;
    logic             busy;
    logic             lookup_miss;
    logic             beat_we;
    logic [CNT_W-1:0] beat_idx;
    logic             fill_done;
    logic             stale;

    // Address split: window bit, line tag, word offset.
    assign in_win     = rd_addr[ADDR_W];
    assign lookup_tag = rd_addr[ADDR_W-1:OFS_W];

    // Processor handshake: complete on an idle hit, otherwise stall.
    assign lookup_miss = rd_req && in_win && !busy && !hit;
    assign rd_valid    = rd_req && in_win && !busy && hit;
    assign rd_stall    = rd_req && in_win && !rd_valid;

    // Burst start address: line-aligned word offset in 16-bit beat units.
    assign burst_addr = {line_tag, {(OFS_W + HALF_SH){1'b0}}};

    lfb_ctrl #(
        .BEATS(BEATS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_miss(lookup_miss),
        .beat_valid (beat_valid),
        .invalidate (invalidate),
        .busy       (busy),
        .beat_we    (beat_we),
        .beat_idx   (beat_idx),
        .fill_done  (fill_done),
        .stale      (stale),
        .burst_req  (burst_req)
    );

    lfb_tag #(
        .TAG_W(TAG_W)
    ) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (lookup_miss),
        .lookup_tag(lookup_tag),
        .fill_done (fill_done),
        .stale     (stale),
        .invalidate(invalidate),
        .tag       (line_tag),
        .hit       (hit)
    );

    lfb_line #(
        .WORD_W    (WORD_W),
        .BEAT_W    (BEAT_W),
        .LINE_WORDS(LINE_WORDS)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_we  (beat_we),
        .beat_idx (beat_idx),
        .beat_data(beat_data),
        .rd_sel   (rd_addr[OFS_W-1:0]),
        .rd_word  (rd_data)
    );

    AST_HIT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !burst_req); // R6
    AST_BURST_ONLY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> $past(rd_req && rd_addr[ADDR_W])); // R2

endmodule

// File: tb/lfb_read_buffer_bench.sv
`timescale 1ns/1ps
module lfb_read_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_stall;
    logic        inval = 1'b0;
    logic        burst_req;
    logic [15:0] burst_addr;
    logic        be_valid = 1'b0;
    logic [15:0] be_data = '0;
    logic        jk_valid = 1'b0;
    logic [15:0] jk_data = '0;
    logic        beat_valid;
    logic [15:0] beat_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_cycles = 0;
    int last_beat_cyc = 0;
    int gap_mode = 0;
    logic [15:0] last_baddr = '0;

    assign beat_valid = be_valid | jk_valid;
    assign beat_data  = jk_valid ? jk_data : be_data;

    always #2.5 clk = ~clk;

    lfb_read_buffer u_lfb_read_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_stall  (rd_stall),
        .invalidate(inval),
        .burst_req (burst_req),
        .burst_addr(burst_addr),
        .beat_valid(beat_valid),
        .beat_data (beat_data)
    );

    function automatic logic [15:0] mem16(input logic [15:0] a);
        logic [15:0] p;
        p = a * 16'h9E37;
        return p ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Burst request monitor: counts high cycles of burst_req.
    always @(negedge clk) begin
        if (rst_n && burst_req) begin
            req_cycles++;
            last_baddr = burst_addr;
        end
    end

    // Back-end model: eight ascending beats per burst, gap_mode idle cycles between beats.
    initial begin
        logic [15:0] base;
        forever begin
            @(negedge clk);
            if (rst_n && burst_req) begin
                base = burst_addr;
                for (int k = 0; k < 8; k++) begin
                    for (int g = 0; g < gap_mode; g++) @(negedge clk);
                    be_valid = 1'b1;
                    be_data  = mem16(base + 16'(k));
                    if (k == 7) last_beat_cyc = cyc;
                    @(negedge clk);
                    be_valid = 1'b0;
                end
            end
        end
    end

    task automatic do_read(input logic [15:0] a, input int nb, input string what);
        int r0;
        int waited;
        bit stall_ok;
        logic [31:0] exp;
        exp = {mem16({a[14:0], 1'b1}), mem16({a[14:0], 1'b0})};
        r0 = req_cycles;
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = a;
        #1;
        waited = 0;
        stall_ok = 1'b1;
        while (!rd_valid && waited < 300) begin
            if (!rd_stall) stall_ok = 1'b0;
            @(negedge clk);
            #1;
            waited++;
        end
        chk(rd_valid === 1'b1 && rd_data === exp, {what, " R4 R6 word"}, rd_data, exp);
        chk(stall_ok, {what, " R5 stall held"}, 32'(stall_ok), 32'd1);
        chk(req_cycles - r0 == nb, {what, " R3 burst count"}, 32'(req_cycles - r0), 32'(nb));
        if (nb == 0) begin
            chk(waited == 0, {what, " R6 same-cycle hit"}, 32'(waited), 32'd0);
        end else begin
            chk(cyc == last_beat_cyc + 1, {what, " R5 return cycle"}, 32'(cyc), 32'(last_beat_cyc + 1));
            chk(last_baddr === {a[14:2], 3'b000}, {what, " R3 burst address"},
                32'(last_baddr), 32'({a[14:2], 3'b000}));
        end
        rd_req = 1'b0;
    endtask

    task automatic out_win(input logic [15:0] a);
        int r0;
        bit quiet;
        r0 = req_cycles;
        quiet = 1'b1;
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = a;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (rd_stall !== 1'b0 || rd_valid !== 1'b0) quiet = 1'b0;
            @(negedge clk);
        end
        rd_req = 1'b0;
        chk(quiet, "R2 outside window quiet", 32'(quiet), 32'd1);
        chk(req_cycles == r0, "R2 outside window no burst", 32'(req_cycles - r0), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] tagv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rd_valid === 1'b0 && rd_stall === 1'b0 && burst_req === 1'b0, "R1 reset outputs",
            {29'd0, rd_valid, rd_stall, burst_req}, 32'd0);
        do_read(16'h8000, 1, "R1 first read");

        // R7 sweep: sixteen lines, each filled by a miss then read at every word.
        for (int l = 0; l < 16; l++) begin
            tagv = (l == 14) ? 13'h0000 : (l == 15) ? 13'h1FFF : 13'(l * 1361 + 5);
            gap_mode = l % 3;
            do_read({1'b1, tagv, 2'(l % 4)}, 1, "R7 miss");
            for (int w = 0; w < 4; w++) begin
                do_read({1'b1, tagv, 2'(w)}, 0, "R6 hit");
            end
        end

        // R2: window bit clear, including a tag equal to the cached one.
        out_win(16'h0123);
        out_win(16'h7FFC);
        do_read(16'hFFFC, 0, "R2 line kept");

        // R10: stray beats while idle.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            jk_valid = 1'b1;
            jk_data = 16'hDEAD;
        end
        @(negedge clk);
        jk_valid = 1'b0;
        for (int w = 0; w < 4; w++) begin
            do_read({14'h3FFF, 2'(w)}, 0, "R10 line unchanged");
        end

        // R8: invalidate while idle.
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        do_read(16'hFFFD, 1, "R8 miss after invalidate");

        // R9: invalidate during a refill forces a second burst.
        gap_mode = 2;
        fork
            do_read(16'h9234, 2, "R9 refetch");
            begin
                repeat (6) @(negedge clk);
                inval = 1'b1;
                @(negedge clk);
                inval = 1'b0;
            end
        join
        do_read(16'h9235, 0, "R9 hit after refetch");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule